// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks one of five free-running clocks and passes it to a clock domain. Software writes a 3-bit source code through a simple write port that runs on a control clock. The block then moves from the current clock to the new one without glitches. It first stops the old clock after one of its falling edges. It waits until a control-domain copy of that state shows the old clock stopped. It then lets the new clock through, again starting after a falling edge of that clock. While the handover runs, the output is held low and a busy flag is set.

Each source has its own lane. A lane has a local reset synchronizer, a two-flop synchronizer that brings in the enable request, and an enable flop clocked on the falling edge of its source. The enable state of every lane is synchronized back into the control domain, and the control sequencer waits on that copy. An instance can be built locked to source code 4. Such an instance refuses every write and never reports busy.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the reported source code is 1, busy is low, and the output runs at the period of source 1.
- R2: The source codes are fixed. Code 0 is the slow real-time clock, code 1 is the crystal oscillator, and codes 2, 3 and 4 are PLL outputs one, two and three. Once a switch to code k completes, the output period equals the period of source k.
- R3: A write with a valid, different code is accepted on the control clock edge where `wr_en` is high. `rd_sel` (bits 2:0 of the status view) shows the new code from the next control cycle.
- R4: `busy` (the status bit next to the select field) is 1 in the control cycle after an accepted write. It stays 1 until the new source is passed to the output, and it then returns to 0.
- R5: A write with a code above 4 is rejected. `rd_sel` keeps its value, `busy` stays low, and the output keeps its source.
- R6: A write that arrives while `busy` is high is ignored. The pending switch completes to the code that was first accepted.
- R7: A write of the code already selected starts no switch, and `busy` stays low.
- R8: The output is glitch-free. Every high phase of `clk_out` is one whole high phase of a source. Every low phase lasts at least half the period of the fastest source. At most one source lane is enabled at any time.
- R9: An instance built locked to source 4 always reports code 4, never raises `busy`, refuses every write, and outputs source 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ctl | input | 1 | Control clock for the write port and the status outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 5 | Source clocks, indexed by select code |
| wr_en | input | 1 | Write strobe for the select field |
| wr_sel | input | 3 | Requested source code |
| rd_sel | output | 3 | Currently selected source code |
| busy | output | 1 | High while a switch is in progress |
| clk_out | output | 1 | Selected, glitch-free output clock |

## Verification
Switches run slow-to-fast (real-time clock to PLL three), fast-to-slow, and between neighbouring PLLs. These cases separate a handover that waits on the right lane from one that only happens to work when both clocks have similar rates. The output period measured after each switch tells a wrong index mapping apart from a correct one. A pulse-width monitor catches a truncated high phase or a too-short low gap at either end of a switch. Invalid codes, a repeated code and a write during busy each test a separate acceptance condition, and a locked instance shows that writes are refused.

// File: rtl/csw_pkg.sv
package csw_pkg;

   localparam int CSW_NUM_SRC_DEF = 5;
   localparam int CSW_SEL_W_DEF   = 3;

   // Fixed source code assignment
   typedef enum logic [2:0] {
      SRC_RTC  = 3'd0,
      SRC_XTAL = 3'd1,
      SRC_PLLA = 3'd2,
      SRC_PLLB = 3'd3,
      SRC_PLLC = 3'd4
   } csw_src_e;

   // Handover sequencer states
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DROP  = 2'd1,
      ST_RAISE = 2'd2
   } csw_state_e;

endpackage

// File: rtl/csw_sync.sv
module csw_sync #(
   parameter int             W       = 5,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("csw_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/csw_lane.sv
module csw_lane #(
   parameter bit INIT_ON = 1'b0,
   parameter int STAGES  = 2
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic req,
   output logic en,
   output logic gated
);

   if (STAGES < 2) begin : g_bad_stages
      $error("csw_lane: STAGES must be at least 2");
   end

   // Local reset: asserted at once, released on the source clock
   logic [1:0] rst_pipe;
   logic       lrst_n;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) rst_pipe <= 2'b00;
      else        rst_pipe <= {rst_pipe[0], 1'b1};
   end
   assign lrst_n = rst_pipe[1];

   // Request synchronizer on rising edges of the source
   logic [STAGES-1:0] req_pipe;

   always_ff @(posedge src_clk or negedge lrst_n) begin
      if (!lrst_n) req_pipe <= {STAGES{INIT_ON}};
      else         req_pipe <= {req_pipe[STAGES-2:0], req};
   end

   // Enable moves only while the source is low
   always_ff @(negedge src_clk or negedge lrst_n) begin
      if (!lrst_n) en <= INIT_ON;
      else         en <= req_pipe[STAGES-1];
   end

   assign gated = src_clk & en;

endmodule

// File: rtl/csw_ctrl.sv
module csw_ctrl
   import csw_pkg::*;
#(
   parameter int NUM_SRC  = CSW_NUM_SRC_DEF,
   parameter int SEL_W    = CSW_SEL_W_DEF,
   parameter int INIT_SRC = 1,
   parameter bit LOCKED   = 1'b0,
   parameter int LOCK_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [NUM_SRC-1:0] ack,
   output logic [NUM_SRC-1:0] want,
   output logic [SEL_W-1:0]   cur_sel,
   output logic               busy
);

   localparam int                 RST_SRC = LOCKED ? LOCK_SRC : INIT_SRC;
   localparam logic [NUM_SRC-1:0] ONE     = NUM_SRC'(1);

   if (LOCKED) begin : g_fixed
      // Source tied off: writes have nowhere to go
      assign want    = ONE << LOCK_SRC;
      assign cur_sel = SEL_W'(LOCK_SRC);
      assign busy    = 1'b0;
   end else begin : g_switch
      csw_state_e         st_q;
      logic [SEL_W-1:0]   sel_q;
      logic [SEL_W-1:0]   old_q;
      logic [NUM_SRC-1:0] want_q;
      logic               code_ok;
      logic               accept;

      assign code_ok = ({1'b0, wr_sel} < (SEL_W+1)'(NUM_SRC));
      assign accept  = wr_en && code_ok && (wr_sel != sel_q) && (st_q == ST_IDLE);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q   <= ST_IDLE;
            sel_q  <= SEL_W'(RST_SRC);
            old_q  <= SEL_W'(RST_SRC);
            want_q <= ONE << RST_SRC;
         end else begin
            unique case (st_q)
               ST_IDLE: begin
                  if (accept) begin
                     old_q  <= sel_q;
                     sel_q  <= wr_sel;
                     want_q <= '0;
                     st_q   <= ST_DROP;
                  end
               end
               ST_DROP: begin
                  // Old lane confirmed stopped before the new one is asked
                  if (!ack[old_q]) begin
                     want_q <= ONE << sel_q;
                     st_q   <= ST_RAISE;
                  end
               end
               ST_RAISE: begin
                  if (ack[sel_q]) st_q <= ST_IDLE;
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end

      assign want    = want_q;
      assign cur_sel = sel_q;
      assign busy    = (st_q != ST_IDLE);
   end

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
   import csw_pkg::*;
#(
   parameter int NUM_SRC  = CSW_NUM_SRC_DEF,
   parameter int SEL_W    = CSW_SEL_W_DEF,
   parameter int INIT_SRC = 1,
   parameter bit LOCKED   = 1'b0,
   parameter int LOCK_SRC = 4,
   parameter int SYNC_STG = 2
) (
   input  logic               clk_ctl,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   output logic [SEL_W-1:0]   rd_sel,
   output logic               busy,
   output logic               clk_out
);

   localparam int                 RST_SRC  = LOCKED ? LOCK_SRC : INIT_SRC;
   localparam logic [NUM_SRC-1:0] RST_MASK = NUM_SRC'(1) << RST_SRC;

   if (NUM_SRC < 2 || NUM_SRC > (1 << SEL_W)) begin : g_bad_count
      $error("clk_src_switch: NUM_SRC does not fit SEL_W");
   end
   if (INIT_SRC >= NUM_SRC || LOCK_SRC >= NUM_SRC) begin : g_bad_src
      $error("clk_src_switch: reset or locked source out of range");
   end

   logic [NUM_SRC-1:0] want;
   logic [NUM_SRC-1:0] lane_en;
   logic [NUM_SRC-1:0] lane_clk;
   logic [NUM_SRC-1:0] ack;

   csw_ctrl #(
      .NUM_SRC  (NUM_SRC),
      .SEL_W    (SEL_W),
      .INIT_SRC (INIT_SRC),
      .LOCKED   (LOCKED),
      .LOCK_SRC (LOCK_SRC)
   ) u_ctrl (
      .clk     (clk_ctl),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .ack     (ack),
      .want    (want),
      .cur_sel (rd_sel),
      .busy    (busy)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      csw_lane #(
         .INIT_ON (i == RST_SRC),
         .STAGES  (SYNC_STG)
      ) u_lane (
         .src_clk (src_clk[i]),
         .rst_n   (rst_n),
         .req     (want[i]),
         .en      (lane_en[i]),
         .gated   (lane_clk[i])
      );
   end

   csw_sync #(
      .W       (NUM_SRC),
      .STAGES  (SYNC_STG),
      .RST_VAL (RST_MASK)
   ) u_ack_sync (
      .clk   (clk_ctl),
      .rst_n (rst_n),
      .d     (lane_en),
      .q     (ack)
   );

   assign clk_out = |lane_clk;

endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk #(
   parameter int NUM_SRC  = 5,
   parameter int SEL_W    = 3,
   parameter bit LOCKED   = 1'b0,
   parameter int LOCK_SRC = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [SEL_W-1:0]   wr_sel,
   input logic [SEL_W-1:0]   rd_sel,
   input logic               busy,
   input logic [NUM_SRC-1:0] lane_en
);

   logic code_ok;
   assign code_ok = ({1'b0, wr_sel} < (SEL_W+1)'(NUM_SRC));

   AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, rd_sel} < (SEL_W+1)'(NUM_SRC)); // R2

   AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!LOCKED && wr_en && code_ok && !busy && wr_sel != rd_sel)
      |=> (busy && rd_sel == $past(wr_sel))); // R4

   AST_BAD_CODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !code_ok) |=> $stable(rd_sel)); // R5

   AST_BUSY_HOLDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rd_sel)); // R6

   AST_SAME_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && wr_sel == rd_sel) |=> (!busy && $stable(rd_sel))); // R7

   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_en)); // R8

   AST_LOCKED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      LOCKED |-> (rd_sel == SEL_W'(LOCK_SRC) && !busy)); // R9

endmodule

bind clk_src_switch clk_src_switch_chk #(
   .NUM_SRC  (NUM_SRC),
   .SEL_W    (SEL_W),
   .LOCKED   (LOCKED),
   .LOCK_SRC (LOCK_SRC)
) u_chk (
   .clk     (clk_ctl),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .rd_sel  (rd_sel),
   .busy    (busy),
   .lane_en (lane_en)
);

// File: tb/test_clk_src_switch.sv
`timescale 1ns/1ps
module test_clk_src_switch;

   localparam real HALF_CTL = 2.5;
   localparam real H0 = 18.5;
   localparam real H1 = 6.0;
   localparam real H2 = 3.5;
   localparam real H3 = 4.5;
   localparam real H4 = 2.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] src = 5'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [2:0] rd_sel, rd_sel_lk;
   logic       busy, busy_lk;
   logic       clk_out, clk_out_lk;

   int vectors = 0;
   int fails   = 0;

   always #(HALF_CTL) clk = ~clk;
   always #(H0) src[0] = ~src[0];
   always #(H1) src[1] = ~src[1];
   always #(H2) src[2] = ~src[2];
   always #(H3) src[3] = ~src[3];
   always #(H4) src[4] = ~src[4];

   clk_src_switch i_clk_src_switch (
      .clk_ctl (clk), .rst_n (rst_n), .src_clk (src),
      .wr_en (wr_en), .wr_sel (wr_sel),
      .rd_sel (rd_sel), .busy (busy), .clk_out (clk_out)
   );

   clk_src_switch #(.LOCKED(1'b1)) i_clk_src_switch_locked (
      .clk_ctl (clk), .rst_n (rst_n), .src_clk (src),
      .wr_en (wr_en), .wr_sel (wr_sel),
      .rd_sel (rd_sel_lk), .busy (busy_lk), .clk_out (clk_out_lk)
   );

   function automatic real src_period(int k);
      case (k)
         0: return 2.0 * H0;
         1: return 2.0 * H1;
         2: return 2.0 * H2;
         3: return 2.0 * H3;
         default: return 2.0 * H4;
      endcase
   endfunction

   task automatic check_int(string tag, int got, int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic check_real(string tag, real got, real exp);
      vectors++;
      if (got - exp > 0.01 || exp - got > 0.01) begin
         fails++;
         $display("FAIL %s: got %0.3f expected %0.3f at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- reference model, compared every control cycle -------------
   int mdl_sel = 1;
   bit mdl_busy_chk = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mdl_sel      <= 1;
         mdl_busy_chk <= 1'b0;
      end else if (wr_en && wr_sel <= 3'd4 && !busy && int'(wr_sel) != mdl_sel) begin
         mdl_sel      <= int'(wr_sel);
         mdl_busy_chk <= 1'b1;
      end else begin
         mdl_busy_chk <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check_int("R3 rd_sel", int'(rd_sel), mdl_sel);
         if (mdl_busy_chk) check_int("R4 busy after accept", int'(busy), 1);
         check_int("R9 locked rd_sel", int'(rd_sel_lk), 4);
         check_int("R9 locked busy", int'(busy_lk), 0);
      end
   end

   // ---------------- pulse-width monitor on the output --------------------------
   bit  mon_on = 1'b0;
   bit  have_fall = 1'b0;
   bit  have_rise = 1'b0;
   real t_rise = 0.0;
   real t_fall = 0.0;

   always @(posedge clk_out) begin
      if (mon_on && have_fall) begin
         vectors++;
         if ($realtime - t_fall < H4 - 0.001) begin
            fails++;
            $display("FAIL R8 low phase: got %0.3f expected >= %0.3f", $realtime - t_fall, H4);
         end
      end
      t_rise    = $realtime;
      have_rise = 1'b1;
   end

   always @(negedge clk_out) begin
      if (mon_on && have_rise) begin
         real w;
         bit  ok;
         w  = $realtime - t_rise;
         ok = 1'b0;
         for (int k = 0; k < 5; k++)
            if (w - src_period(k) / 2.0 < 0.01 && src_period(k) / 2.0 - w < 0.01) ok = 1'b1;
         vectors++;
         if (!ok) begin
            fails++;
            $display("FAIL R8 high phase: got %0.3f expected a source half period", w);
         end
      end
      t_fall    = $realtime;
      have_fall = 1'b1;
   end

   // ---------------- stimulus helpers ---------------------------------------------
   task automatic write_code(int c);
      @(negedge clk);
      wr_en  = 1'b1;
      wr_sel = 3'(c);
      @(negedge clk);
      wr_en  = 1'b0;
   endtask

   task automatic wait_idle(string tag);
      int n = 0;
      while (busy && n < 1000) begin
         @(negedge clk);
         n++;
      end
      check_int(tag, int'(busy), 0);
   endtask

   task automatic measure(string tag, bit lk, int k);
      real t0, t1;
      if (lk) begin
         @(posedge clk_out_lk); @(posedge clk_out_lk); t0 = $realtime;
         @(posedge clk_out_lk); t1 = $realtime;
      end else begin
         @(posedge clk_out); @(posedge clk_out); t0 = $realtime;
         @(posedge clk_out); t1 = $realtime;
      end
      check_real(tag, t1 - t0, src_period(k));
   endtask

   task automatic switch_to(int k, string tag);
      write_code(k);
      check_int({tag, " busy raised"}, int'(busy), 1);
      check_int({tag, " code"}, int'(rd_sel), k);
      wait_idle({tag, " busy cleared"});
      measure({tag, " period"}, 1'b0, k);
   endtask

   // ---------------- main sequence -----------------------------------------------
   initial begin
      repeat (4) @(negedge clk);
      check_int("R1 reset code", int'(rd_sel), 1);
      check_int("R1 reset busy", int'(busy), 0);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      mon_on = 1'b1;
      check_int("R1 code after release", int'(rd_sel), 1);
      measure("R1 period src1", 1'b0, 1);

      switch_to(3, "R2 to pll two");
      switch_to(0, "R2 fast to slow rtc");
      switch_to(4, "R2 slow to fast pll three");
      switch_to(2, "R2 to pll one");
      switch_to(1, "R2 back to xtal");

      // R5: codes above 4
      write_code(5);
      check_int("R5 code 5 busy", int'(busy), 0);
      check_int("R5 code 5 sel", int'(rd_sel), 1);
      write_code(7);
      check_int("R5 code 7 busy", int'(busy), 0);
      check_int("R5 code 7 sel", int'(rd_sel), 1);
      measure("R5 period kept", 1'b0, 1);

      // R7: same code again
      write_code(1);
      check_int("R7 same code busy", int'(busy), 0);
      check_int("R7 same code sel", int'(rd_sel), 1);

      // R6: write while busy
      write_code(0);
      check_int("R6 first write busy", int'(busy), 1);
      write_code(3);
      check_int("R6 second write ignored", int'(rd_sel), 0);
      wait_idle("R6 busy cleared");
      check_int("R6 final code", int'(rd_sel), 0);
      measure("R6 period rtc", 1'b0, 0);

      // R9: locked instance saw every write above
      measure("R9 locked period", 1'b1, 4);
      switch_to(2, "R4 last switch");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule